// File: doc/BRIEF.md
# CAN Receive Slot Chain Allocator

This block turns a chain of receive message slots into one receive queue for a CAN controller. Each frame that has passed acceptance filtering arrives as a one-cycle strobe with its contents. The block writes the frame into the lowest-numbered slot whose pending flag is clear and then sets that flag. No head or tail pointer exists. The set of pending flags alone decides where the next frame goes.

The host reads any slot through a combinational read port. Each slot returns its stored frame and the arrival sequence number it received when it was stored. Reading has no side effect. The host returns slots to the free pool in a separate step, by applying a clear mask that can release several slots at once. A clear that meets an incoming frame in the same cycle never costs that frame. A frame that finds every slot occupied is discarded, and the discard raises a sticky loss flag and steps a saturating overflow counter, so a loss is always visible.

Slot indices run from 0 to NUM_SLOTS-1. Index 0 is the lowest slot, which is filled first.

Top module: `canRxSlotFifo`

## Requirements
- R1: While reset is asserted and right after it is released, `pending` is all zero, `msgLost` is 0 and `ovfCount` is 0.
- R2: A frame strobed on `frameValid` is stored in the lowest index whose pending bit was clear in that cycle. That bit reads 1 from the following cycle on.
- R3: `rdData` and `rdSeq` show the contents of slot `rdSlot` combinationally. Changing `rdSlot` never alters `pending`, and a slot keeps its contents until a later frame is stored into it.
- R4: With `clrValid` high, every slot whose bit is 1 in `clrMask` has its pending bit cleared on the next cycle. Several bits can be cleared in one cycle.
- R5: While low slots stay pending, new frames fill higher slots. Once the low slots are cleared, storing starts again from index 0.
- R6: When a clear and a frame arrive in the same cycle and some slot was already free, the frame goes to the lowest slot that was free before the clear. Slots cleared in that cycle are not chosen, and the frame lands in exactly one slot.
- R7: When the slot chosen for a store also has its `clrMask` bit set in the same cycle, the store wins and that pending bit ends up 1.
- R8: When every slot is pending and a clear arrives together with a frame, the frame goes to the lowest slot being cleared in that cycle. It is not discarded.
- R9: When every slot is pending and no clear arrives, the frame is discarded. `pending` and all slot contents stay unchanged, `msgLost` becomes 1 and stays 1 until reset, and `ovfCount` increases by one, holding at its maximum value.
- R10: A sequence counter starts at 0 after reset. Each stored frame copies the counter into its slot's `rdSeq` and then advances it by one, modulo 2^SEQ_W. Discarded frames do not advance it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameValid | input | 1 | One-cycle strobe of an accepted frame |
| frameData | input | DATA_W | Frame contents to store |
| clrValid | input | 1 | Apply `clrMask` this cycle |
| clrMask | input | NUM_SLOTS | Slots whose pending bit is cleared |
| rdSlot | input | $clog2(NUM_SLOTS) | Slot selected for reading |
| rdData | output | DATA_W | Contents of the selected slot |
| rdSeq | output | SEQ_W | Arrival sequence number of the selected slot |
| pending | output | NUM_SLOTS | Per-slot pending flags |
| msgLost | output | 1 | Sticky flag, set when a frame is discarded |
| ovfCount | output | OVF_W | Saturating count of discarded frames |

## Verification
If the pending flags or the slot selection go wrong, the fault shows on `pending` one cycle after the offending store or clear. The new bit lands at the wrong index, or a bit count that should have grown by one does not. A store steered into a slot other than the one the host expects appears as soon as the host reads that slot: the data or the sequence number does not match. A frame that is silently lost leaves `msgLost` at 0 and `ovfCount` unchanged in the next cycle, while the queue of expected frames still holds one entry that no slot can produce.

// File: rtl/canRxSlotFifoPkg.sv
package canRxSlotFifoPkg;
  // Slot index width carried in the strobe struct. It supports chains of up to 256 slots.
  localparam int unsigned IDX_MAX_W = 8;

  typedef struct packed {
    logic                 store;  // commit frameData into slot
    logic                 drop;   // frame discarded, all slots busy
    logic [IDX_MAX_W-1:0] slot;   // target slot of the store
  } slotStrobe_t;
endpackage

// File: rtl/canRxSlotCtrl.sv
module canRxSlotCtrl
  import canRxSlotFifoPkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameValid,
  input  logic                 clrValid,
  input  logic [NUM_SLOTS-1:0] clrMask,
  output logic [NUM_SLOTS-1:0] pending,
  output slotStrobe_t          strobe
);
  localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0] pendingQ, pendingD;
  logic [NUM_SLOTS-1:0] clrEff, freeVec, clrHit, setVec;
  logic [IDX_W-1:0]     freeIdx, clrIdx, selIdx;
  logic                 haveFree, haveClr, doStore;

  // Lowest free slot first. A slot released in this same cycle is used only when no other slot is free.
  always_comb begin
    clrEff   = clrValid ? clrMask : '0;
    freeVec  = ~pendingQ;
    clrHit   = pendingQ & clrEff;
    haveFree = |freeVec;
    haveClr  = |clrHit;
    freeIdx  = '0;
    clrIdx   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (freeVec[i]) freeIdx = IDX_W'(i);
      if (clrHit[i])  clrIdx  = IDX_W'(i);
    end
    selIdx  = haveFree ? freeIdx : clrIdx;
    doStore = frameValid & (haveFree | haveClr);
    setVec  = doStore ? (NUM_SLOTS'(1) << selIdx) : '0;
    // store beats clear on the same slot
    pendingD = (pendingQ & ~clrEff) | setVec;

    strobe.store = doStore;
    strobe.drop  = frameValid & ~(haveFree | haveClr);
    strobe.slot  = IDX_MAX_W'(selIdx);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendingQ <= '0;
    else       pendingQ <= pendingD;
  end

  assign pending = pendingQ;
endmodule

// File: rtl/canRxSlotData.sv
module canRxSlotData
  import canRxSlotFifoPkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEQ_W     = 8,
  parameter int unsigned OVF_W     = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  slotStrobe_t          strobe,
  input  logic [DATA_W-1:0]    frameData,
  input  logic [((NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1)-1:0] rdSlot,
  output logic [DATA_W-1:0]    rdData,
  output logic [SEQ_W-1:0]     rdSeq,
  output logic                 msgLost,
  output logic [OVF_W-1:0]     ovfCount
);
  logic [DATA_W-1:0] slotData [NUM_SLOTS];
  logic [SEQ_W-1:0]  slotSeq  [NUM_SLOTS];
  logic [SEQ_W-1:0]  seqCnt;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotData[g] <= '0;
        slotSeq[g]  <= '0;
      end else if (strobe.store && strobe.slot == IDX_MAX_W'(g)) begin
        slotData[g] <= frameData;
        slotSeq[g]  <= seqCnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqCnt   <= '0;
      msgLost  <= 1'b0;
      ovfCount <= '0;
    end else begin
      if (strobe.store) seqCnt <= seqCnt + 1'b1;
      if (strobe.drop) begin
        msgLost <= 1'b1;
        if (ovfCount != '1) ovfCount <= ovfCount + 1'b1;
      end
    end
  end

  assign rdData = slotData[rdSlot];
  assign rdSeq  = slotSeq[rdSlot];
endmodule

// File: rtl/canRxSlotFifo.sv
module canRxSlotFifo
  import canRxSlotFifoPkg::*;
#(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEQ_W     = 8,
  parameter int unsigned OVF_W     = 8,
  localparam int unsigned IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameValid,
  input  logic [DATA_W-1:0]    frameData,
  input  logic                 clrValid,
  input  logic [NUM_SLOTS-1:0] clrMask,
  input  logic [IDX_W-1:0]     rdSlot,
  output logic [DATA_W-1:0]    rdData,
  output logic [SEQ_W-1:0]     rdSeq,
  output logic [NUM_SLOTS-1:0] pending,
  output logic                 msgLost,
  output logic [OVF_W-1:0]     ovfCount
);
  slotStrobe_t strobe;

  canRxSlotCtrl #(.NUM_SLOTS(NUM_SLOTS)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameValid(frameValid),
    .clrValid(clrValid), .clrMask(clrMask),
    .pending(pending), .strobe(strobe)
  );

  canRxSlotData #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .SEQ_W(SEQ_W), .OVF_W(OVF_W)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameData(frameData),
    .rdSlot(rdSlot), .rdData(rdData), .rdSeq(rdSeq),
    .msgLost(msgLost), .ovfCount(ovfCount)
  );
endmodule

// File: rtl/canRxSlotFifoChk.sv
module canRxSlotFifoChk #(
  parameter int unsigned NUM_SLOTS = 16,
  parameter int unsigned OVF_W     = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 frameValid,
  input logic                 clrValid,
  input logic [NUM_SLOTS-1:0] clrMask,
  input logic [NUM_SLOTS-1:0] pending,
  input logic                 msgLost,
  input logic [OVF_W-1:0]     ovfCount
);
  always @(negedge clk) begin
    if (!rstN) begin
      p_reset_state_r1: assert (pending == '0 && !msgLost && ovfCount == '0);
    end
  end

  p_lowest_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameValid && !pending[0] |=> pending[0]);

  p_one_flag_per_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    frameValid && !clrValid && !(&pending) |=>
      $countones(pending) == $past($countones(pending)) + 1);

  p_read_no_effect_r3: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid && !clrValid |=> $stable(pending));

  p_clear_applies_r4: assert property (@(posedge clk) disable iff (!rstN)
    clrValid && !frameValid |=> (pending & $past(clrMask)) == '0);

  p_full_clear_stores_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameValid && (&pending) && clrValid && (|clrMask) |=>
      $countones(pending) == $past($countones(pending & ~clrMask)) + 1);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameValid && (&pending) && !(clrValid && (|clrMask)) |=> msgLost && $stable(pending));

  p_lost_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    msgLost |=> msgLost);

  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    ovfCount != $past(ovfCount) |-> $past(frameValid && (&pending)));
endmodule

bind canRxSlotFifo canRxSlotFifoChk #(.NUM_SLOTS(NUM_SLOTS), .OVF_W(OVF_W)) chk_i (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .clrValid(clrValid),
  .clrMask(clrMask), .pending(pending), .msgLost(msgLost), .ovfCount(ovfCount)
);

// File: tb/canRxSlotFifo_tb_top.sv
module canRxSlotFifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameValid = 1'b0;
  logic [31:0] frameData = '0;
  logic        clrValid = 1'b0;
  logic [15:0] clrMask = '0;
  logic [3:0]  rdSlot = '0;
  logic [31:0] rdData;
  logic [7:0]  rdSeq;
  logic [15:0] pending;
  logic        msgLost;
  logic [7:0]  ovfCount;

  always #(CLK_PERIOD / 2) clk = ~clk;

  canRxSlotFifo dut_i (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
    .clrValid(clrValid), .clrMask(clrMask), .rdSlot(rdSlot),
    .rdData(rdData), .rdSeq(rdSeq), .pending(pending),
    .msgLost(msgLost), .ovfCount(ovfCount)
  );

  typedef struct {
    int          slot;
    logic [31:0] data;
    logic [7:0]  seq;
    string       req;
  } expItem_t;

  expItem_t    sbQ[$];
  int          nChecks = 0;
  int          nFails = 0;
  logic [15:0] mPend = '0;
  logic [31:0] mData [NS];
  logic [7:0]  mSeq = '0;
  logic        mLost = 1'b0;
  logic [7:0]  mOvf = '0;
  bit          done = 1'b0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: take the expected stores off the scoreboard and compare them against the read port.
  task automatic monitorDrain();
    while (sbQ.size() > 0) begin
      expItem_t it = sbQ.pop_front();
      rdSlot = 4'(it.slot);
      #1;
      check(it.req, "rdData", 64'(rdData), 64'(it.data));
      check("R10", "rdSeq", 64'(rdSeq), 64'(it.seq));
    end
  endtask

  // Driver: apply one cycle of stimulus, update the model and push the expected store.
  task automatic op(bit fv, logic [31:0] fd, bit cv, logic [15:0] cm, string req);
    logic [15:0] clrEff;
    int sel;
    @(negedge clk);
    frameValid = fv; frameData = fd; clrValid = cv; clrMask = cm;
    clrEff = cv ? cm : 16'h0;
    sel = -1;
    if (fv) begin
      for (int i = 0; i < NS; i++) if (!mPend[i]) begin sel = i; break; end
      if (sel < 0)
        for (int i = 0; i < NS; i++) if (mPend[i] && clrEff[i]) begin sel = i; break; end
    end
    mPend = mPend & ~clrEff;
    if (sel >= 0) begin
      mPend[sel] = 1'b1;
      mData[sel] = fd;
      sbQ.push_back('{slot: sel, data: fd, seq: mSeq, req: req});
      mSeq = mSeq + 8'd1;
    end else if (fv) begin
      mLost = 1'b1;
      if (mOvf != 8'hFF) mOvf = mOvf + 8'd1;
    end
    @(negedge clk);
    frameValid = 1'b0; clrValid = 1'b0; clrMask = '0;
    check(req, "pending", 64'(pending), 64'(mPend));
    check(req, "msgLost", 64'(msgLost), 64'(mLost));
    check(req, "ovfCount", 64'(ovfCount), 64'(mOvf));
    monitorDrain();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) mData[i] = '0;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", "pending in reset", 64'(pending), 64'h0);
    check("R1", "msgLost in reset", 64'(msgLost), 64'h0);
    check("R1", "ovfCount in reset", 64'(ovfCount), 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "pending after reset", 64'(pending), 64'h0);

    // R2 lowest free slot, three frames to slots 0,1,2
    op(1, 32'hA000_0001, 0, 16'h0, "R2");
    op(1, 32'hA000_0002, 0, 16'h0, "R2");
    op(1, 32'hA000_0003, 0, 16'h0, "R2");

    // R3 reading leaves flags and contents alone
    rdSlot = 4'd1; #1;
    check("R3", "rdData slot1", 64'(rdData), 64'h A000_0002);
    rdSlot = 4'd2; #1;
    op(0, 32'h0, 0, 16'h0, "R3");
    rdSlot = 4'd0; #1;
    check("R3", "rdData slot0 kept", 64'(rdData), 64'h A000_0001);

    // R4 clear slots 0 and 2 in one write
    op(0, 32'h0, 1, 16'h0005, "R4");
    // R5 store resumes from slot 0, then slot 2, then slot 3
    op(1, 32'hB000_0000, 0, 16'h0, "R5");
    op(1, 32'hB000_0002, 0, 16'h0, "R5");
    op(1, 32'hB000_0003, 0, 16'h0, "R5");
    // R5 fill the rest
    for (int i = 4; i < NS; i++) op(1, 32'hC000_0000 + 32'(i), 0, 16'h0, "R5");
    check("R5", "all pending", 64'(pending), 64'hFFFF);

    // R9 full, no clear: discard
    op(1, 32'hDEAD_0000, 0, 16'h0, "R9");
    for (int i = 0; i < NS; i++) begin
      rdSlot = 4'(i); #1;
      check("R9", "slot contents kept", 64'(rdData), 64'(mData[i]));
    end

    // R8 full with clear of slots 5 and 9: frame goes to slot 5
    op(1, 32'hE000_0005, 1, 16'h0220, "R8");
    // R6 slot 9 free, clear slot 0 with a store: frame to slot 9
    op(1, 32'hE000_0009, 1, 16'h0001, "R6");
    // R7 slot 0 free, store and clear both aim at slot 0: store wins
    op(1, 32'hE000_0000, 1, 16'h0001, "R7");
    check("R7", "slot0 pending", 64'(pending[0]), 64'h1);

    // R9 saturation of the overflow counter
    for (int i = 0; i < 260; i++) op(1, 32'hF000_0000 + 32'(i), 0, 16'h0, "R9");
    check("R9", "ovfCount saturated", 64'(ovfCount), 64'hFF);

    // R10 sequence wrap with constant clears alongside stores
    op(0, 32'h0, 1, 16'hFFFF, "R4");
    for (int i = 0; i < 280; i++) op(1, 32'h1234_0000 + 32'(i), 1, 16'hFFFF, "R10");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule